// File: doc/BRIEF.md
# Weight to DWRR Cost Converter

This block turns up to eight per-queue bandwidth weights into the cost values that a deficit weighted round-robin scheduler consumes. Software places a weight for every queue and a mask of enabled queues on the inputs, then pulses `start_i`. The block captures both, finds the smallest weight among the enabled queues, and gives each enabled queue a cost that shrinks as its weight grows. A heavier queue therefore gets a smaller cost.

Each cost comes from a restoring shift-subtract divider that yields one quotient bit per cycle. The queues are handled one after another. When every slot is written the block pulses `done_i`-style completion on `done_o`. It also reports how many queues were enabled. It raises an error instead of dividing when an enabled queue carries a zero weight.

Top module: `wcost_conv`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `err_o` are low, `active_cnt_o` is 0 and every cost slot is 0.
- R2: A `start_i` seen while idle captures `weights_i` and `enable_i`. From the next cycle `busy_o` is high until completion. `done_o` is high for exactly one cycle per accepted start.
- R3: The reference weight is the minimum of 100 and the weights of all enabled queues. Weights of disabled queues do not affect it.
- R4: For an enabled queue of weight w, with q = floor(512 * wmin / w) and r = (q + 8) >> 4, the slot holds max(r, 1) - 1. Slot i occupies bits [5i+4:5i] of `costs_o`.
- R5: Every disabled queue's slot reads 0 when `done_o` is high.
- R6: When `done_o` is high without error, `active_cnt_o` equals the number of set bits in the captured enable mask.
- R7: If any enabled queue has weight 0, no division is started. `err_o` is set and reads 1 at `done_o`, every slot is 0, and `active_cnt_o` is 0. A zero weight on a disabled queue is not an error.
- R8: A `start_i` that arrives while `busy_o` is high is ignored. The run in progress finishes with the inputs captured at its own start, and no further completion follows.
- R9: After `done_o`, `costs_o`, `active_cnt_o` and `err_o` hold their values regardless of input changes until the next accepted start.
- R10: With an empty enable mask the block completes with no error, a count of 0 and all slots 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| arst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a conversion (honoured only when idle) |
| weights_i | input | NQ*WW (56) | Queue weights, queue i at bits [7i+6:7i] |
| enable_i | input | NQ (8) | Enabled-queue mask, bit i for queue i |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Enabled queue with zero weight detected |
| active_cnt_o | output | CNTW (4) | Number of enabled queues |
| costs_o | output | NQ*CW (40) | Encoded cost per queue, slot i at bits [5i+4:5i] |

## Verification
The hardest situation to reach from the ports is a second start that lands in the middle of a long serial division. If it were accepted, the block would quietly mix two input sets. The stimulus holds the first job's inputs only on the start cycle. It then presents a different weight set and mask with a start pulse several cycles into the run. The scoreboard expects exactly one result, matching the first job, and flags any extra completion. The cases that reach the clamping and ceiling paths are also covered. Weights above 100 drive the reference to its starting value, and weights of 1 and 100 together drive the costs to both ends of the 5-bit range.

// File: rtl/wcost_pkg.sv
package wcost_pkg;

  localparam int unsigned DEF_NQ        = 8;
  localparam int unsigned DEF_WW        = 7;
  localparam int unsigned DEF_SCALE_LOG = 5;
  localparam int unsigned DEF_FRAC      = 4;
  localparam int unsigned DEF_W_INIT    = 100;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CHECK = 3'd1,
    ST_NEXT  = 3'd2,
    ST_WAIT  = 3'd3,
    ST_FIN   = 3'd4
  } wcost_state_e;

endpackage

// File: rtl/wcost_rst_sync.sv
module wcost_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/wcost_scan.sv
module wcost_scan #(
  parameter int unsigned NQ     = 8,
  parameter int unsigned WW     = 7,
  parameter int unsigned W_INIT = 100,
  parameter int unsigned CNTW   = 4
) (
  input  logic [NQ-1:0][WW-1:0] w_i,
  input  logic [NQ-1:0]         en_i,
  output logic [WW-1:0]         wmin_o,
  output logic                  zero_o,
  output logic [CNTW-1:0]       cnt_o
);

  // Reference weight, zero-weight flag and enabled count over the mask
  always_comb begin
    wmin_o = WW'(W_INIT);
    zero_o = 1'b0;
    cnt_o  = '0;
    for (int i = 0; i < int'(NQ); i++) begin
      if (en_i[i]) begin
        cnt_o = cnt_o + CNTW'(1);
        if (w_i[i] == '0)    zero_o = 1'b1;
        if (w_i[i] < wmin_o) wmin_o = w_i[i];
      end
    end
  end

endmodule

// File: rtl/wcost_serial_div.sv
module wcost_serial_div #(
  parameter int unsigned DW = 16,
  parameter int unsigned VW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [VW-1:0] divisor_i,
  output logic          valid_o,
  output logic [DW-1:0] quot_o
);

  localparam int unsigned SW = $clog2(DW + 1);
  localparam logic [SW-1:0] STEP_LAST = SW'(DW - 1);

  logic [VW-1:0] rem_q, rem_n;
  logic [DW-1:0] quo_q, quo_n;
  logic [VW-1:0] dvs_q, dvs_n;
  logic [SW-1:0] step_q, step_n;
  logic          run_q, run_n;
  logic          valid_q, valid_n;
  logic [VW:0]   trial, diff;
  logic          ge;
  logic          upd_en;

  always_comb begin
    trial   = {rem_q, quo_q[DW-1]};
    ge      = (trial >= {1'b0, dvs_q});
    diff    = trial - {1'b0, dvs_q};
    rem_n   = rem_q;
    quo_n   = quo_q;
    dvs_n   = dvs_q;
    step_n  = step_q;
    run_n   = run_q;
    upd_en  = start_i | run_q;
    valid_n = run_q && (step_q == STEP_LAST);
    if (start_i) begin
      rem_n  = '0;
      quo_n  = dividend_i;
      dvs_n  = divisor_i;
      step_n = '0;
      run_n  = 1'b1;
    end else if (run_q) begin
      rem_n  = ge ? diff[VW-1:0] : trial[VW-1:0];
      quo_n  = {quo_q[DW-2:0], ge};
      step_n = step_q + SW'(1);
      run_n  = (step_q != STEP_LAST);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q   <= '0;
      quo_q   <= '0;
      dvs_q   <= '0;
      step_q  <= '0;
      run_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_n;
      if (upd_en) begin
        rem_q  <= rem_n;
        quo_q  <= quo_n;
        dvs_q  <= dvs_n;
        step_q <= step_n;
        run_q  <= run_n;
      end
    end
  end

  assign valid_o = valid_q;
  assign quot_o  = quo_q;

  // Finished remainder must be below the divisor (cost arithmetic, R4)
  assert_rem_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (rem_q < dvs_q));

  // A running division never has a zero divisor (R7)
  assert_no_zero_div_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (dvs_q != '0));

endmodule

// File: rtl/wcost_conv.sv
module wcost_conv
  import wcost_pkg::*;
#(
  parameter int unsigned NQ        = DEF_NQ,
  parameter int unsigned WW        = DEF_WW,
  parameter int unsigned SCALE_LOG = DEF_SCALE_LOG,
  parameter int unsigned FRAC      = DEF_FRAC,
  parameter int unsigned W_INIT    = DEF_W_INIT,
  localparam int unsigned CW       = SCALE_LOG,
  localparam int unsigned CNTW     = $clog2(NQ + 1)
) (
  input  logic               clk_i,
  input  logic               arst_ni,
  input  logic               start_i,
  input  logic [NQ*WW-1:0]   weights_i,
  input  logic [NQ-1:0]      enable_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o,
  output logic [CNTW-1:0]    active_cnt_o,
  output logic [NQ*CW-1:0]   costs_o
);

  localparam int unsigned SH = SCALE_LOG + FRAC;
  localparam int unsigned DW = WW + SH;
  localparam int unsigned IW = $clog2(NQ + 1);
  localparam int unsigned QW = (NQ > 1) ? $clog2(NQ) : 1;
  localparam logic [IW-1:0] IDX_END = IW'(NQ);
  localparam logic [DW:0]   RND_HALF = (DW+1)'(1) << (FRAC - 1);

  logic rst_n;

  wcost_state_e            state_q, state_n;
  logic [NQ-1:0][WW-1:0]   w_q;
  logic [NQ-1:0]           m_q;
  logic                    cap_en;
  logic [IW-1:0]           idx_q, idx_n;
  logic [QW-1:0]           qsel;
  logic [WW-1:0]           wmin_q, wmin_n;
  logic [CNTW-1:0]         cnt_q, cnt_n;
  logic                    err_q, err_n;
  logic [NQ-1:0][CW-1:0]   costs_q, costs_n;
  logic                    div_go, div_valid;
  logic [DW-1:0]           div_quot;
  logic [WW-1:0]           scan_wmin;
  logic                    scan_zero;
  logic [CNTW-1:0]         scan_cnt;

  function automatic logic [CW-1:0] encode_cost(input logic [DW-1:0] q);
    logic [DW:0] r;
    r = ({1'b0, q} + RND_HALF) >> FRAC;
    if (r == '0) return '0;
    return CW'(r - (DW+1)'(1));
  endfunction

  wcost_rst_sync u_rst_sync (
    .clk_i  (clk_i),
    .arst_ni(arst_ni),
    .rst_no (rst_n)
  );

  wcost_scan #(
    .NQ    (NQ),
    .WW    (WW),
    .W_INIT(W_INIT),
    .CNTW  (CNTW)
  ) u_scan (
    .w_i   (w_q),
    .en_i  (m_q),
    .wmin_o(scan_wmin),
    .zero_o(scan_zero),
    .cnt_o (scan_cnt)
  );

  assign qsel = idx_q[QW-1:0];

  wcost_serial_div #(
    .DW(DW),
    .VW(WW)
  ) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .start_i   (div_go),
    .dividend_i({wmin_q, {SH{1'b0}}}),
    .divisor_i (w_q[qsel]),
    .valid_o   (div_valid),
    .quot_o    (div_quot)
  );

  assign cap_en = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_n = state_q;
    idx_n   = idx_q;
    wmin_n  = wmin_q;
    cnt_n   = cnt_q;
    err_n   = err_q;
    costs_n = costs_q;
    div_go  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          costs_n = '0;
          cnt_n   = '0;
          err_n   = 1'b0;
          state_n = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (scan_zero) begin
          err_n   = 1'b1;
          state_n = ST_FIN;
        end else begin
          wmin_n  = scan_wmin;
          cnt_n   = scan_cnt;
          idx_n   = '0;
          state_n = ST_NEXT;
        end
      end
      ST_NEXT: begin
        if (idx_q == IDX_END) begin
          state_n = ST_FIN;
        end else if (m_q[qsel]) begin
          div_go  = 1'b1;
          state_n = ST_WAIT;
        end else begin
          idx_n = idx_q + IW'(1);
        end
      end
      ST_WAIT: begin
        if (div_valid) begin
          costs_n[qsel] = encode_cost(div_quot);
          idx_n         = idx_q + IW'(1);
          state_n       = ST_NEXT;
        end
      end
      ST_FIN:  state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      wmin_q  <= '0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
      costs_q <= '0;
      w_q     <= '0;
      m_q     <= '0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      wmin_q  <= wmin_n;
      cnt_q   <= cnt_n;
      err_q   <= err_n;
      costs_q <= costs_n;
      if (cap_en) begin
        w_q <= weights_i;
        m_q <= enable_i;
      end
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = (state_q == ST_FIN);
  assign err_o        = err_q;
  assign active_cnt_o = cnt_q;
  assign costs_o      = costs_q;

  // Completion is a single-cycle pulse (R2)
  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |=> !done_o);

  // Disabled slots read zero at completion (R5)
  for (genvar g = 0; g < int'(NQ); g++) begin : g_slot_chk
    assert_disabled_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
      (done_o && !m_q[g]) |-> (costs_q[g] == '0));
  end

  // Reported count matches the captured mask (R6)
  assert_count_match_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_o && !err_q) |-> (cnt_q == CNTW'($countones(m_q))));

  // Error result carries no costs and no count (R7)
  assert_err_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_o && err_q) |-> ((costs_q == '0) && (cnt_q == '0)));

  // A start during a run leaves captured inputs untouched (R8)
  assert_ignore_start_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(m_q) && $stable(w_q)));

endmodule

// File: tb/wcost_conv_bench.sv
module wcost_conv_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NQ = 8;
  localparam int WW = 7;
  localparam int CW = 5;
  localparam int CNTW = 4;

  typedef struct {
    logic [NQ*CW-1:0] costs;
    int               cnt;
    bit               err;
    string            tag;
  } exp_t;

  logic              clk;
  logic              arst_n;
  logic              start;
  logic [NQ*WW-1:0]  weights;
  logic [NQ-1:0]     enable;
  logic              busy, done, err;
  logic [CNTW-1:0]   cnt;
  logic [NQ*CW-1:0]  costs;

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   finished = 0;
  bit   prev_done = 0;
  exp_t exp_q[$];
  exp_t last_exp;

  wcost_conv u_wcost_conv (
    .clk_i       (clk),
    .arst_ni     (arst_n),
    .start_i     (start),
    .weights_i   (weights),
    .enable_i    (enable),
    .busy_o      (busy),
    .done_o      (done),
    .err_o       (err),
    .active_cnt_o(cnt),
    .costs_o     (costs)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string msg);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic exp_t model(input int w[NQ], input logic [NQ-1:0] m, input string tag);
    exp_t e;
    int wmin, q, r;
    wmin = 100; e.costs = '0; e.cnt = 0; e.err = 0; e.tag = tag;
    for (int i = 0; i < NQ; i++) begin
      if (m[i]) begin
        e.cnt++;
        if (w[i] == 0) e.err = 1;
        else if (w[i] < wmin) wmin = w[i];
      end
    end
    if (e.err) begin
      e.cnt = 0;
      return e;
    end
    for (int i = 0; i < NQ; i++) begin
      if (m[i]) begin
        q = (512 * wmin) / w[i];
        r = (q + 8) >> 4;
        if (r < 1) r = 1;
        e.costs[i*CW +: CW] = CW'(r - 1);
      end
    end
    return e;
  endfunction

  function automatic logic [NQ*WW-1:0] pack_w(input int w[NQ]);
    logic [NQ*WW-1:0] v;
    for (int i = 0; i < NQ; i++) v[i*WW +: WW] = WW'(w[i]);
    return v;
  endfunction

  // Monitor: pop expected result at each completion and compare
  always @(negedge clk) begin
    if (arst_n && !finished) begin
      if (prev_done && done)
        check(0, $sformatf("R2 done longer than one cycle act=1 exp=0"));
      if (done) begin
        if (exp_q.size() == 0) begin
          check(0, "R8 unexpected completion act=done exp=none");
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          last_exp = e;
          check(costs === e.costs, $sformatf("R4/R5 %s costs act=%h exp=%h", e.tag, costs, e.costs));
          check(int'(cnt) == e.cnt, $sformatf("R6 %s count act=%0d exp=%0d", e.tag, cnt, e.cnt));
          check(err === e.err, $sformatf("R7 %s err act=%0b exp=%0b", e.tag, err, e.err));
        end
      end
      prev_done = done;
    end
  end

  task automatic run_case(input int w[NQ], input logic [NQ-1:0] m, input string tag,
                          input bit poke_busy);
    exp_t e;
    e = model(w, m, tag);
    exp_q.push_back(e);
    @(negedge clk);
    weights = pack_w(w);
    enable  = m;
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
    weights = '1;
    enable  = '0;
    check(busy === 1'b1, $sformatf("R2 %s busy after start act=%0b exp=1", tag, busy));
    if (poke_busy) begin
      // R8: different job offered while busy
      repeat (4) @(negedge clk);
      weights = pack_w('{3, 3, 3, 3, 3, 3, 3, 3});
      enable  = 8'hFF;
      start   = 1'b1;
      @(negedge clk);
      start   = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    arst_n  = 1'b0;
    start   = 1'b0;
    weights = '0;
    enable  = '0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check(busy === 0 && done === 0 && err === 0,
          $sformatf("R1 flags act=%0b%0b%0b exp=000", busy, done, err));
    check(cnt === '0 && costs === '0,
          $sformatf("R1 outputs act=%0d/%h exp=0/0", cnt, costs));

    // R4 ascending weights, all enabled
    run_case('{10, 20, 30, 40, 50, 60, 70, 80}, 8'hFF, "ascending", 0);
    // R5 R6 sparse mask, disabled zero weight is legal (R7)
    run_case('{17, 0, 45, 9, 0, 99, 0, 33}, 8'b1010_1101, "sparse", 0);
    // R3 all enabled weights above 100
    run_case('{120, 101, 127, 110, 105, 126, 115, 118}, 8'hFF, "above100", 0);
    // R3 small weight on a disabled queue must not set reference
    run_case('{1, 50, 60, 70, 80, 90, 100, 40}, 8'hFE, "disabled_min", 0);
    // R4 range ends: weight 1 against 100
    run_case('{1, 100, 1, 100, 64, 2, 3, 99}, 8'hFF, "extremes", 0);
    // R4 equal weights
    run_case('{25, 25, 25, 25, 25, 25, 25, 25}, 8'hFF, "equal", 0);
    // R10 empty mask
    run_case('{5, 6, 7, 8, 9, 10, 11, 12}, 8'h00, "empty", 0);
    // R7 zero weight on enabled queue
    run_case('{30, 40, 0, 50, 60, 70, 80, 90}, 8'hFF, "zero_err", 0);
    // R7 error is cleared by the next good run
    run_case('{7, 14, 21, 28, 35, 42, 49, 56}, 8'h3C, "after_err", 0);
    // R8 start while busy ignored
    run_case('{11, 22, 33, 44, 55, 66, 77, 88}, 8'hF3, "busy_poke", 1);

    // R9 outputs hold after completion despite input changes
    weights = pack_w('{1, 1, 1, 1, 1, 1, 1, 1});
    enable  = 8'h55;
    repeat (20) @(negedge clk);
    check(costs === last_exp.costs, $sformatf("R9 costs hold act=%h exp=%h", costs, last_exp.costs));
    check(int'(cnt) == last_exp.cnt, $sformatf("R9 count hold act=%0d exp=%0d", cnt, last_exp.cnt));
    check(busy === 0, $sformatf("R8 no extra run act=%0b exp=0", busy));

    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, $sformatf("R2 pending results act=%0d exp=0", exp_q.size()));
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL R2 watchdog expired act=hung exp=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule